// File: doc/BRIEF.md
# Interrupt claim/complete controller

This block gathers level-triggered interrupt sources and routes them to several targets, such as processor cores. Each source has a gateway that tracks two states, pending and in service. Each target has its own enable mask over the sources. A target's request line is high while at least one source is pending, not in service, and enabled for it.

Handling an interrupt follows a fixed sequence. A target reads its claim port and gets back the ID of the lowest-numbered source that is eligible for it. In the same cycle that source leaves the pending state and enters the in-service state. When the handler is done, the target writes an ID to its claim port to complete it. A completion is never compared with what that target claimed. It is accepted only when the written ID is currently enabled for the writing target; otherwise it is silently dropped and the source stays blocked.

A configuration port writes and reads the enable masks. A build-time parameter selects an optional mode in which a claim also clears the claimed source's enable bit for the claiming target.

Top module: `irqcc_top`

## Requirements
- R1: After a synchronous reset, every pending, in-service and enable bit is zero, and irq_o, clm_rid and cfg_rdata read zero.
- R2: irq_o[t] is registered. After each clock edge it is high exactly when some source is pending, not in service, and enabled for target t. A source that is asserted while it is neither pending nor in service becomes pending at that edge. Source ID k is src_irq bit k-1.
- R3: A claim read (clm_valid[t]=1, clm_write[t]=0) puts an ID on clm_rid field t (bits t*ID_W upward) one cycle later. The ID is the lowest-numbered source that is pending and enabled for t, or 0 if there is none. The field is 0 in any cycle that follows no claim read.
- R4: A claim clears the source's pending bit and sets its in-service bit at the same edge. While the source is in service, it does not become pending again and raises no request, even if it stays asserted.
- R5: A completion write (clm_valid[t]=1, clm_write[t]=1, ID on clm_wid field t) of an ID that is enabled for t clears that source's in-service bit. If the source is still asserted, it is pending again one edge later.
- R6: A completion is not checked against the ID the target claimed. Any target may complete a source if the ID is enabled for it. If the ID is not enabled for the writing target, the write is discarded and the source stays in service.
- R7: A completion write of ID 0, or of an ID greater than NUM_SRC, changes nothing.
- R8: When a configuration write and a completion write fall in the same cycle, the completion is judged against the newly written enable mask.
- R9: With AUTO_MASK=1, a claim clears the claimed source's enable bit for the claiming target. With AUTO_MASK=0, claims leave the enables unchanged.
- R10: When several targets claim in the same cycle, they are served in increasing target index. Each later target picks only among the sources not taken by earlier ones, so no two targets get the same nonzero ID.
- R11: A configuration read (cfg_re=1) returns the enable mask of target cfg_tgt on cfg_rdata one cycle later, with bit k-1 standing for source ID k. The value is 0 when no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Level interrupt inputs, bit k-1 is source ID k |
| cfg_we | input | 1 | Write cfg_wdata to the enable mask of cfg_tgt |
| cfg_re | input | 1 | Read the enable mask of cfg_tgt |
| cfg_tgt | input | TGT_W | Target selected by the configuration port |
| cfg_wdata | input | NUM_SRC | Enable mask to write |
| cfg_rdata | output | NUM_SRC | Enable mask read, one cycle after cfg_re |
| clm_valid | input | NUM_TGT | Per-target claim port access strobe |
| clm_write | input | NUM_TGT | Per-target access type, 1 means completion write |
| clm_wid | input | NUM_TGT*ID_W | Per-target completion IDs, field t at t*ID_W |
| clm_rid | output | NUM_TGT*ID_W | Per-target claimed IDs, one cycle after the read |
| irq_o | output | NUM_TGT | Per-target interrupt request |

## Verification
The hardest state to reach is a source held in service while its ID is not enabled for a target that tries to complete it. The stimulus produces it three ways: a target completes a source that another target claimed, the auto-mask mode clears the claimer's own enable, and an enable write lands in the same cycle as a completion write. After each of these, the bench keeps the source asserted and watches whether a request or a claim ID reappears, which shows whether the completion was taken or dropped. A second instance built with auto-masking runs the same stimulus. A random phase then mixes claims from both targets in the same cycle with completions of in-range, out-of-range and zero IDs.

// File: rtl/irqcc_pkg.sv
package irqcc_pkg;

  // Width of an ID field: IDs run 0..n, with 0 reserved for "nothing".
  function automatic int idw(input int n);
    return (n > 0) ? $clog2(n + 1) : 1;
  endfunction

  // Width of a target select field.
  function automatic int selw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irqcc_gateway.sv
module irqcc_gateway #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic [NUM_SRC-1:0] claim_set,
  input  logic [NUM_SRC-1:0] done_clr,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] insvc_q,
  output logic [NUM_SRC-1:0] pend_d,
  output logic [NUM_SRC-1:0] insvc_d
);

  // One gateway per source: a claim takes precedence over everything; a
  // source re-arms only once its in-service bit has been cleared.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign pend_d[s]  = claim_set[s] ? 1'b0
                                     : (pend_q[s] | (src_irq[s] & ~insvc_q[s]));
    assign insvc_d[s] = claim_set[s] | (insvc_q[s] & ~done_clr[s]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      insvc_q <= '0;
    end else begin
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

endmodule

// File: rtl/irqcc_enables.sv
module irqcc_enables #(
  parameter int NUM_SRC   = 8,
  parameter int NUM_TGT   = 2,
  parameter bit AUTO_MASK = 1'b0,
  parameter int TGT_W     = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [TGT_W-1:0]                cfg_tgt,
  input  logic [NUM_SRC-1:0]              cfg_wdata,
  input  logic [NUM_TGT-1:0][NUM_SRC-1:0] grant,
  output logic [NUM_TGT-1:0][NUM_SRC-1:0] en_q,
  output logic [NUM_TGT-1:0][NUM_SRC-1:0] en_w,
  output logic [NUM_TGT-1:0][NUM_SRC-1:0] en_d
);

  localparam logic [NUM_SRC-1:0] AM_MASK = {NUM_SRC{AUTO_MASK}};

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    // Software write lands first; completions are judged against en_w.
    assign en_w[t] = (cfg_we && cfg_tgt == TGT_W'(t)) ? cfg_wdata : en_q[t];
    // Optional auto-mask on claim is applied on top of the write.
    assign en_d[t] = en_w[t] & ~(grant[t] & AM_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

endmodule

// File: rtl/irqcc_picker.sv
module irqcc_picker #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 4
) (
  input  logic               req,
  input  logic [NUM_SRC-1:0] elig,
  output logic [NUM_SRC-1:0] grant,
  output logic [ID_W-1:0]    gid
);

  // Lowest-numbered eligible source wins: scan downward, last hit sticks.
  always_comb begin
    grant = '0;
    gid   = '0;
    if (req) begin
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
        if (elig[s]) begin
          grant    = '0;
          grant[s] = 1'b1;
          gid      = ID_W'(s + 1);
        end
      end
    end
  end

endmodule

// File: rtl/irqcc_top.sv
module irqcc_top #(
  parameter  int NUM_SRC   = 8,
  parameter  int NUM_TGT   = 2,
  parameter  bit AUTO_MASK = 1'b0,
  localparam int ID_W      = irqcc_pkg::idw(NUM_SRC),
  localparam int TGT_W     = irqcc_pkg::selw(NUM_TGT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_SRC-1:0]      src_irq,
  input  logic                    cfg_we,
  input  logic                    cfg_re,
  input  logic [TGT_W-1:0]        cfg_tgt,
  input  logic [NUM_SRC-1:0]      cfg_wdata,
  output logic [NUM_SRC-1:0]      cfg_rdata,
  input  logic [NUM_TGT-1:0]      clm_valid,
  input  logic [NUM_TGT-1:0]      clm_write,
  input  logic [NUM_TGT*ID_W-1:0] clm_wid,
  output logic [NUM_TGT*ID_W-1:0] clm_rid,
  output logic [NUM_TGT-1:0]      irq_o
);

  logic [NUM_SRC-1:0] pend_q, insvc_q, pend_d, insvc_d;
  logic [NUM_SRC-1:0] claim_set, done_clr, cfg_rd_d;
  logic [NUM_TGT-1:0][NUM_SRC-1:0] en_q, en_w, en_d, grant, taken;
  logic [NUM_TGT-1:0][ID_W-1:0]    gid;

  irqcc_gateway #(.NUM_SRC(NUM_SRC)) u_gateway (
    .clk(clk), .rst(rst), .src_irq(src_irq),
    .claim_set(claim_set), .done_clr(done_clr),
    .pend_q(pend_q), .insvc_q(insvc_q), .pend_d(pend_d), .insvc_d(insvc_d)
  );

  irqcc_enables #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .AUTO_MASK(AUTO_MASK), .TGT_W(TGT_W)
  ) u_enables (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt),
    .cfg_wdata(cfg_wdata), .grant(grant),
    .en_q(en_q), .en_w(en_w), .en_d(en_d)
  );

  // Claim chain: target t only sees sources not granted to targets below it.
  assign taken[0] = '0;
  for (genvar t = 1; t < NUM_TGT; t++) begin : g_chain
    assign taken[t] = taken[t-1] | grant[t-1];
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_pick
    irqcc_picker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_picker (
      .req  (clm_valid[t] & ~clm_write[t]),
      .elig (pend_q & en_q[t] & ~taken[t]),
      .grant(grant[t]),
      .gid  (gid[t])
    );
  end

  always_comb begin
    claim_set = '0;
    for (int t = 0; t < NUM_TGT; t++) claim_set = claim_set | grant[t];
  end

  // Completion: accepted only when the ID is enabled (after this cycle's
  // configuration write) for the writing target. ID 0 and IDs past
  // NUM_SRC never match any source.
  always_comb begin
    done_clr = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (clm_valid[t] && clm_write[t]) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (clm_wid[t*ID_W +: ID_W] == ID_W'(s + 1) && en_w[t][s])
            done_clr[s] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    cfg_rd_d = '0;
    if (cfg_re) begin
      for (int t = 0; t < NUM_TGT; t++) begin
        if (cfg_tgt == TGT_W'(t)) cfg_rd_d = en_q[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= '0;
      clm_rid   <= '0;
      cfg_rdata <= '0;
    end else begin
      for (int t = 0; t < NUM_TGT; t++) begin
        irq_o[t]                  <= |(pend_d & ~insvc_d & en_d[t]);
        clm_rid[t*ID_W +: ID_W]   <= gid[t];
      end
      cfg_rdata <= cfg_rd_d;
    end
  end

endmodule

// File: rtl/irqcc_chk.sv
module irqcc_chk #(
  parameter int NUM_SRC   = 8,
  parameter int NUM_TGT   = 2,
  parameter bit AUTO_MASK = 1'b0,
  parameter int ID_W      = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic [NUM_SRC-1:0]              pend_q,
  input logic [NUM_SRC-1:0]              insvc_q,
  input logic [NUM_TGT-1:0][NUM_SRC-1:0] en_q,
  input logic [NUM_TGT-1:0]              irq_o,
  input logic [NUM_TGT-1:0]              clm_valid,
  input logic [NUM_TGT-1:0]              clm_write,
  input logic [NUM_TGT*ID_W-1:0]         clm_rid
);

  logic [NUM_TGT-1:0] rid_enabled;
  always_comb begin
    rid_enabled = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (clm_rid[t*ID_W +: ID_W] == ID_W'(s + 1) && en_q[t][s])
          rid_enabled[t] = 1'b1;
      end
    end
  end

  // R4
  pend_insvc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q & insvc_q) == '0);

  // R4
  no_repend_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & $past(insvc_q)) == '0);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
    // R2
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[t] == |(pend_q & ~insvc_q & en_q[t]));

    // R3
    rid_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !(clm_valid[t] && !clm_write[t]) |=> clm_rid[t*ID_W +: ID_W] == '0);

    // R9
    if (AUTO_MASK) begin : g_am
      automask_chk: assert property (@(posedge clk) disable iff (rst)
        !rid_enabled[t]);
    end

    for (genvar u = t + 1; u < NUM_TGT; u++) begin : g_u
      // R10
      distinct_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (clm_rid[t*ID_W +: ID_W] == '0) ||
        (clm_rid[t*ID_W +: ID_W] != clm_rid[u*ID_W +: ID_W]));
    end
  end

endmodule

bind irqcc_top irqcc_chk #(
  .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .AUTO_MASK(AUTO_MASK), .ID_W(ID_W)
) u_irqcc_chk (
  .clk(clk), .rst(rst), .pend_q(pend_q), .insvc_q(insvc_q), .en_q(en_q),
  .irq_o(irq_o), .clm_valid(clm_valid), .clm_write(clm_write),
  .clm_rid(clm_rid)
);

// File: tb/test_irqcc_top.sv
module test_irqcc_top;

  localparam int NS  = 8;
  localparam int NT  = 2;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [NS-1:0]     src_irq = '0;
  logic              cfg_we = 1'b0, cfg_re = 1'b0;
  logic [0:0]        cfg_tgt = '0;
  logic [NS-1:0]     cfg_wdata = '0;
  logic [NT-1:0]     clm_valid = '0, clm_write = '0;
  logic [NT*IDW-1:0] clm_wid = '0;

  logic [NS-1:0]     cfg_rd0, cfg_rd1;
  logic [NT*IDW-1:0] rid0, rid1;
  logic [NT-1:0]     irq0, irq1;

  irqcc_top #(.NUM_SRC(NS), .NUM_TGT(NT), .AUTO_MASK(1'b0)) i_irqcc_top (
    .clk(clk), .rst(rst), .src_irq(src_irq), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_tgt(cfg_tgt), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rd0),
    .clm_valid(clm_valid), .clm_write(clm_write), .clm_wid(clm_wid),
    .clm_rid(rid0), .irq_o(irq0));

  irqcc_top #(.NUM_SRC(NS), .NUM_TGT(NT), .AUTO_MASK(1'b1)) i_irqcc_top_am (
    .clk(clk), .rst(rst), .src_irq(src_irq), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_tgt(cfg_tgt), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rd1),
    .clm_valid(clm_valid), .clm_write(clm_write), .clm_wid(clm_wid),
    .clm_rid(rid1), .irq_o(irq1));

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model (index 1 = auto-mask) ----
  logic [NS-1:0]  m_pend[2], m_ins[2], m_cfg[2];
  logic [NS-1:0]  m_en[2][NT];
  logic [NT-1:0]  m_irq[2];
  logic [IDW-1:0] m_rid[2][NT];

  task automatic model_step(input int d);
    logic [NS-1:0] taken, clr, np, ni;
    logic [NS-1:0] ne[NT];
    int pick, id;
    taken = '0; clr = '0;
    for (int t = 0; t < NT; t++) begin
      m_rid[d][t] = '0;
      if (clm_valid[t] && !clm_write[t]) begin
        pick = 0;
        for (int s = 1; s <= NS; s++)
          if (pick == 0 && m_pend[d][s-1] && m_en[d][t][s-1] && !taken[s-1]) pick = s;
        if (pick != 0) begin
          taken[pick-1] = 1'b1;
          m_rid[d][t]   = IDW'(pick);
        end
      end
    end
    m_cfg[d] = cfg_re ? m_en[d][cfg_tgt] : '0;
    for (int t = 0; t < NT; t++) ne[t] = m_en[d][t];
    if (cfg_we) ne[cfg_tgt] = cfg_wdata;
    for (int t = 0; t < NT; t++) begin
      if (clm_valid[t] && clm_write[t]) begin
        id = int'(clm_wid[t*IDW +: IDW]);
        if (id >= 1 && id <= NS && ne[t][id-1]) clr[id-1] = 1'b1;
      end
    end
    if (d == 1)
      for (int t = 0; t < NT; t++)
        if (m_rid[d][t] != '0) ne[t][int'(m_rid[d][t]) - 1] = 1'b0;
    np = (m_pend[d] | (src_irq & ~m_ins[d])) & ~taken;
    ni = (m_ins[d] & ~clr) | taken;
    m_pend[d] = np;
    m_ins[d]  = ni;
    for (int t = 0; t < NT; t++) begin
      m_en[d][t]  = ne[t];
      m_irq[d][t] = |(np & ~ni & ne[t]);
    end
  endtask

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        m_pend[d] = '0; m_ins[d] = '0; m_cfg[d] = '0; m_irq[d] = '0;
        for (int t = 0; t < NT; t++) begin
          m_en[d][t] = '0; m_rid[d][t] = '0;
        end
      end else begin
        model_step(d);
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 irq model dut0", 32'(irq0), 32'(m_irq[0]));
      chk("R2 irq model dut1", 32'(irq1), 32'(m_irq[1]));
      chk("R11 cfg read model dut0", 32'(cfg_rd0), 32'(m_cfg[0]));
      chk("R11 cfg read model dut1", 32'(cfg_rd1), 32'(m_cfg[1]));
      for (int t = 0; t < NT; t++) begin
        chk("R3 claim id model dut0", 32'(rid0[t*IDW +: IDW]), 32'(m_rid[0][t]));
        chk("R3 claim id model dut1", 32'(rid1[t*IDW +: IDW]), 32'(m_rid[1][t]));
      end
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 1'b0; cfg_re = 1'b0; clm_valid = '0; clm_write = '0; clm_wid = '0;
  endtask

  task automatic complete(input int t, input int id);
    clm_valid[t] = 1'b1; clm_write[t] = 1'b1; clm_wid[t*IDW +: IDW] = IDW'(id);
  endtask

  initial begin
    idle();
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 irq after reset", 32'(irq0), 32'h0);
    chk("R1 claim id after reset", 32'(rid0), 32'h0);
    cfg_re = 1'b1; cfg_tgt = 1'b0; step(); idle();
    chk("R1 enables after reset", 32'(cfg_rd0), 32'h0);

    // enables: t0 = IDs 2,3 ; t1 = IDs 3,4
    cfg_we = 1'b1; cfg_tgt = 1'b0; cfg_wdata = 8'h06; step();
    cfg_tgt = 1'b1; cfg_wdata = 8'h0C; step(); idle();
    cfg_re = 1'b1; cfg_tgt = 1'b1; step(); idle();
    chk("R11 cfg read t1", 32'(cfg_rd0), 32'h0C);

    // R2: sources 2 and 3 assert
    src_irq = 8'h06; step();
    chk("R2 irq both targets", 32'(irq0), 32'h3);

    // R10: both targets claim in the same cycle
    clm_valid = 2'b11; step(); idle();
    chk("R10 t0 gets lowest", 32'(rid0[0 +: IDW]), 32'd2);
    chk("R10 t1 gets next", 32'(rid0[IDW +: IDW]), 32'd3);
    chk("R10 am t1 gets next", 32'(rid1[IDW +: IDW]), 32'd3);
    chk("R4 irq drops on claim", 32'(irq0), 32'h0);
    repeat (3) step();
    chk("R4 no request while in service", 32'(irq0), 32'h0);
    clm_valid = 2'b01; step(); idle();
    chk("R3 empty claim returns 0", 32'(rid0[0 +: IDW]), 32'd0);

    // R9: auto-mask cleared claimed enables only in the second instance
    cfg_re = 1'b1; cfg_tgt = 1'b0; step();
    chk("R9 am t0 enable", 32'(cfg_rd1), 32'h04);
    chk("R9 plain t0 enable", 32'(cfg_rd0), 32'h06);
    cfg_tgt = 1'b1; step(); idle();
    chk("R9 am t1 enable", 32'(cfg_rd1), 32'h08);

    // R7: ID 0 and out-of-range IDs are ignored
    complete(0, 0); step();
    complete(0, 9); step();
    complete(0, 15); step(); idle();
    step(); step();
    chk("R7 bad ids ignored", 32'(irq0), 32'h0);

    // R6: completion of an ID not enabled for the writer is discarded
    complete(1, 2); step(); idle();
    step(); step();
    chk("R6 disabled id discarded", 32'(irq0), 32'h0);

    // R5/R6: t0 completes ID 3, claimed by t1; enabled for t0 -> accepted
    complete(0, 3); step(); idle();
    step();
    chk("R5 re-pend after completion", 32'(irq0), 32'h3);
    chk("R9 am re-pend only t0", 32'(irq1), 32'h1);

    // R8: enable write clears ID2 for t0 in the same cycle as its completion
    cfg_we = 1'b1; cfg_tgt = 1'b0; cfg_wdata = 8'h00; complete(0, 2); step(); idle();
    step();
    chk("R8 discard after same-cycle disable", 32'(irq0), 32'h2);
    cfg_we = 1'b1; cfg_tgt = 1'b0; cfg_wdata = 8'h02; step(); idle();
    step();
    chk("R8 id2 still in service", 32'(irq0[0]), 32'h0);
    // R8: same-cycle enable of ID2 for t1 makes its completion valid
    cfg_we = 1'b1; cfg_tgt = 1'b1; cfg_wdata = 8'h0E; complete(1, 2); step(); idle();
    step();
    clm_valid = 2'b10; step(); idle();
    chk("R8 accepted after same-cycle enable", 32'(rid0[IDW +: IDW]), 32'd2);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      src_irq   = NS'($urandom);
      clm_valid = NT'($urandom);
      clm_write = NT'($urandom);
      clm_wid   = {IDW'($urandom_range(0, 10)), IDW'($urandom_range(0, 10))};
      cfg_we    = ($urandom_range(0, 5) == 0);
      cfg_re    = 1'($urandom);
      cfg_tgt   = 1'($urandom);
      cfg_wdata = NS'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule